// File: doc/BRIEF.md
# Countdown Timer with End-of-Interrupt Clear

This block is one 32-bit down-counter. It sits on a simple register bus that has a write strobe, a read strobe, a byte address and 32-bit data. Every access completes in a single cycle, and read data is valid in the same cycle as the read strobe. Software writes a start value and picks a behaviour for expiry. Then it turns the counter on. When the count steps from one to zero, a pending flag is set and a level interrupt line is driven, unless the line is masked.

The interrupt is acknowledged by reading a dedicated acknowledge register. That read returns the interrupt state and clears the flag on the same clock edge. Turning the counter off and on again restarts it from the stored start value. An optional mode holds the counter after it is turned on, until a pulse arrives on an external trigger pin.

Top module: `countdown_timer`

## Requirements
- R12: After reset, every register reads zero and `irqOut` is low.
- R1: Offset 0x00 holds the start value and reads back what was written. Offset 0x08 is the control register. It keeps only bit 0 (run), bit 1 (reload mode), bit 2 (mask) and bit 4 (wait for trigger), and its other bits read zero.
- R2: A control write that changes run from 0 to 1 loads the counter from the start value on that edge. On each later edge the counter falls by one while run is 1. While run is 0 the counter holds its value. Offset 0x04 reads the counter.
- R3: On the edge where the counter goes from 1 to 0 while running, the pending flag is set.
- R4: With bit 1 set, a running counter that sits at zero is reloaded with the start value on the next edge.
- R5: With bit 1 clear, a running counter at zero wraps to all ones on the next edge.
- R6: `irqOut` equals pending AND NOT mask. Bit 0 of offset 0x10 reads the same value. The pending flag is kept while the mask is set.
- R7: A read of offset 0x0C returns the `irqOut` value in bit 0 and clears the pending flag on that edge.
- R8: If an acknowledge read happens on the same edge as a 1-to-0 step, the pending flag stays set.
- R9: A control write with run = 0 clears the pending flag. While run is 0 the flag stays clear.
- R10: If bit 4 is set in the control write that starts the counter, the counter holds the start value until `hwTrig` is high on an edge. Counting down begins on the edge after that.
- R11: Writes to offsets 0x04, 0x0C and 0x10 change nothing. Reads of any offset outside the five used ones return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, single cycle |
| busRd | input | 1 | Read strobe, single cycle |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of `busRd` |
| hwTrig | input | 1 | External start trigger, synchronous to `clk` |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- `hwTrig` and both bus strobes are synchronous to `clk`.
- Address and data are stable across the edge that captures them.
- A write that turns the counter off wins over an expiry in the same cycle.

The bench keeps to these assumptions. It changes every input only on the falling edge. It never issues a write and a read in the same cycle. It pulses the trigger for exactly one cycle.

// File: rtl/countdown_timer_pkg.sv
package countdown_timer_pkg;
  // register byte offsets
  localparam int unsigned OFS_START = 32'h00;
  localparam int unsigned OFS_COUNT = 32'h04;
  localparam int unsigned OFS_CTRL  = 32'h08;
  localparam int unsigned OFS_ACK   = 32'h0C;
  localparam int unsigned OFS_STAT  = 32'h10;

  // control bit positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_RELOAD = 1;
  localparam int BIT_MASK   = 2;
  localparam int BIT_TRIG   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic startLoad;   // load counter from start value
    logic countEn;     // decrement / wrap / reload this edge
    logic reloadMode;  // 1: reload at zero, 0: wrap
  } dpStrobe_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import countdown_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              expireHit
);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic atZero;
  assign atZero    = (countVal == ZERO);
  assign expireHit = strobe.countEn && (countVal == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= ZERO;
    end else if (strobe.startLoad) begin
      countVal <= loadVal;
    end else if (strobe.countEn) begin
      if (atZero && strobe.reloadMode) countVal <= loadVal;
      else                             countVal <= countVal - ONE;
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import countdown_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              hwTrig,
  input  logic [DATA_W-1:0] countVal,
  input  logic              expireHit,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] loadVal,
  output logic              enBit,
  output logic              maskBit,
  output logic              modeBit,
  output logic              pendingFlag,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

  logic trigBit;
  logic waitTrig;
  logic wrStart, wrCtrl, rdAck;
  logic turnOn, turnOff;

  assign wrStart = busWr && (busAddr == A_START);
  assign wrCtrl  = busWr && (busAddr == A_CTRL);
  assign rdAck   = busRd && (busAddr == A_ACK);
  assign turnOn  = wrCtrl &&  busWdata[BIT_RUN] && !enBit;
  assign turnOff = wrCtrl && !busWdata[BIT_RUN];

  assign irqOut = pendingFlag && !maskBit;

  always_comb begin
    strobe.startLoad  = turnOn;
    strobe.countEn    = enBit && !waitTrig && !turnOn;
    strobe.reloadMode = modeBit;
  end

  // start value register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        loadVal <= '0;
    else if (wrStart) loadVal <= busWdata;
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      modeBit <= 1'b0;
      maskBit <= 1'b0;
      trigBit <= 1'b0;
    end else if (wrCtrl) begin
      enBit   <= busWdata[BIT_RUN];
      modeBit <= busWdata[BIT_RELOAD];
      maskBit <= busWdata[BIT_MASK];
      trigBit <= busWdata[BIT_TRIG];
    end
  end

  // hold-for-trigger state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     waitTrig <= 1'b0;
    else if (turnOn)               waitTrig <= busWdata[BIT_TRIG];
    else if (turnOff)              waitTrig <= 1'b0;
    else if (waitTrig && hwTrig)   waitTrig <= 1'b0;
  end

  // pending flag: turning off wins, then expiry, then acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendingFlag <= 1'b0;
    else if (turnOff)   pendingFlag <= 1'b0;
    else if (expireHit) pendingFlag <= 1'b1;
    else if (rdAck)     pendingFlag <= 1'b0;
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (busRd) begin
      unique case (busAddr)
        A_START: busRdata = loadVal;
        A_COUNT: busRdata = countVal;
        A_CTRL: begin
          busRdata[BIT_RUN]    = enBit;
          busRdata[BIT_RELOAD] = modeBit;
          busRdata[BIT_MASK]   = maskBit;
          busRdata[BIT_TRIG]   = trigBit;
        end
        A_ACK:   busRdata[0] = irqOut;
        A_STAT:  busRdata[0] = irqOut;
        default: busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import countdown_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              hwTrig,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] countVal;
  logic              expireHit;
  logic              enBit, maskBit, modeBit, pendingFlag;

  timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .hwTrig(hwTrig),
    .countVal(countVal), .expireHit(expireHit),
    .strobe(strobe), .loadVal(loadVal),
    .enBit(enBit), .maskBit(maskBit), .modeBit(modeBit),
    .pendingFlag(pendingFlag), .irqOut(irqOut)
  );

  timer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .loadVal(loadVal),
    .countVal(countVal), .expireHit(expireHit)
  );
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqOut,
  input logic              enBit,
  input logic              maskBit,
  input logic              modeBit,
  input logic              pendingFlag,
  input logic              expireHit,
  input logic              startLoad,
  input logic              countEn,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] loadVal
);
  // R6: a set mask keeps the line low
  a_r6_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rstN)
    maskBit |-> !irqOut);

  // R2: a stopped counter that is not being started keeps its value
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !startLoad) |=> $stable(countVal));

  // R3: a 1-to-0 step leaves the flag set unless the counter was turned off
  a_r3_expiry_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    expireHit |=> (pendingFlag || !enBit));

  // R5: wrap from zero in free mode
  a_r5_free_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !modeBit && countVal == '0) |=> (countVal == {DATA_W{1'b1}}));

  // R4: reload from zero in reload mode
  a_r4_user_reload: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && modeBit && countVal == '0) |=> (countVal == $past(loadVal)));

  // R9: a stopped timer never has a pending flag
  a_r9_off_clears_pending: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> !pendingFlag);
endmodule

bind countdown_timer countdown_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut),
  .enBit(enBit), .maskBit(maskBit), .modeBit(modeBit),
  .pendingFlag(pendingFlag), .expireHit(expireHit),
  .startLoad(strobe.startLoad), .countEn(strobe.countEn),
  .countVal(countVal), .loadVal(loadVal)
);

// File: tb/sim_countdown_timer.sv
`timescale 1ns/1ps
module sim_countdown_timer;
  localparam logic [7:0] A_START = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_ACK = 8'h0C, A_STAT = 8'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0, hwTrig = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nVec = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  countdown_timer u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .hwTrig(hwTrig), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks are entered and left on a falling edge; one rising edge in between
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected counter k edges after a start with value L (L > 3, k <= L+3)
  function automatic logic [31:0] expCount(input int L, input int k, input bit reload);
    if (k <= L) return 32'(L - k);
    if (reload) return 32'(L - (k - L - 1));
    return 32'hFFFF_FFFF - 32'(k - L - 1);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a;
    int L, L2;
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset values
    chk("R12 irq", {31'b0, irqOut}, 0);
    rd(A_START, v); chk("R12 start", v, 0);
    rd(A_COUNT, v); chk("R12 count", v, 0);
    rd(A_CTRL, v);  chk("R12 ctrl", v, 0);
    rd(A_STAT, v);  chk("R12 status", v, 0);

    // R1 readback
    a = $urandom;
    wr(A_START, a); rd(A_START, v); chk("R1 start readback", v, a);
    wr(A_CTRL, 32'h16); rd(A_CTRL, v); chk("R1 ctrl bits", v, 32'h16);
    wr(A_CTRL, 32'hFFFF_FFE8); rd(A_CTRL, v); chk("R1 reserved bits", v, 0);
    wr(A_CTRL, 0);

    // R2/R3/R4/R7 reload mode
    L = 6 + int'($urandom % 30);
    wr(A_START, 32'(L)); wr(A_CTRL, 32'h3);
    for (int k = 0; k < L; k++) begin
      chk("R3 irq low before expiry", {31'b0, irqOut}, 0);
      rd(A_COUNT, v); chk("R2 count down", v, 32'(L - k));
    end
    chk("R3 irq at expiry", {31'b0, irqOut}, 1);
    rd(A_STAT, v);  chk("R3 status", v, 1);
    rd(A_COUNT, v); chk("R4 reload", v, 32'(L));
    rd(A_ACK, v);   chk("R7 ack value", v, 1);
    rd(A_STAT, v);  chk("R7 cleared", v, 0);
    chk("R7 irq low", {31'b0, irqOut}, 0);

    // R8 ack coinciding with expiry
    wr(A_CTRL, 0); wr(A_START, 32'(L)); wr(A_CTRL, 32'h3);
    idle(L); idle(L);
    rd(A_ACK, v);   chk("R8 ack value", v, 1);
    rd(A_STAT, v);  chk("R8 stays pending", v, 1);
    rd(A_COUNT, v); chk("R4 reload again", v, 32'(L));

    // R5 free mode wrap
    wr(A_CTRL, 0); wr(A_START, 32'(L)); wr(A_CTRL, 32'h1);
    idle(L);
    chk("R3 irq free mode", {31'b0, irqOut}, 1);
    rd(A_STAT, v);  chk("R3 status free mode", v, 1);
    rd(A_COUNT, v); chk("R5 wrap", v, 32'hFFFF_FFFF);
    rd(A_COUNT, v); chk("R5 after wrap", v, 32'hFFFF_FFFE);

    // R6 mask
    wr(A_CTRL, 0); wr(A_START, 32'(L)); wr(A_CTRL, 32'h5);
    idle(L + 2);
    chk("R6 masked irq", {31'b0, irqOut}, 0);
    rd(A_STAT, v);  chk("R6 masked status", v, 0);
    wr(A_CTRL, 32'h1);
    chk("R6 unmasked irq", {31'b0, irqOut}, 1);
    rd(A_STAT, v);  chk("R6 unmasked status", v, 1);

    // R9 turning off clears; R2 hold while off
    wr(A_CTRL, 0);
    chk("R9 irq", {31'b0, irqOut}, 0);
    rd(A_STAT, v); chk("R9 status", v, 0);
    rd(A_COUNT, a); idle(3); rd(A_COUNT, v); chk("R2 hold when off", v, a);

    // R11 read-only writes and unmapped reads
    wr(A_COUNT, 32'h1234); wr(A_STAT, 32'h1); wr(A_ACK, 32'h1);
    rd(A_COUNT, v); chk("R11 count untouched", v, a);
    rd(A_STAT, v);  chk("R11 status untouched", v, 0);
    rd(8'h14, v);   chk("R11 unmapped 0x14", v, 0);
    rd(8'h20, v);   chk("R11 unmapped 0x20", v, 0);
    rd(8'h09, v);   chk("R11 unmapped 0x09", v, 0);

    // R2 restart
    L2 = 10 + int'($urandom % 50);
    wr(A_START, 32'(L2)); wr(A_CTRL, 32'h3);
    rd(A_COUNT, v); chk("R2 start value", v, 32'(L2));
    idle(2);
    wr(A_START, 32'(L)); wr(A_CTRL, 0); wr(A_CTRL, 32'h3);
    rd(A_COUNT, v); chk("R2 restart new value", v, 32'(L));

    // R10 trigger hold
    wr(A_CTRL, 0); wr(A_START, 32'(L)); wr(A_CTRL, 32'h13);
    rd(A_COUNT, v); chk("R10 held", v, 32'(L));
    idle(5);
    rd(A_COUNT, v); chk("R10 still held", v, 32'(L));
    hwTrig = 1'b1; @(negedge clk); hwTrig = 1'b0;
    rd(A_COUNT, v); chk("R10 first after trigger", v, 32'(L));
    rd(A_COUNT, v); chk("R10 counting", v, 32'(L - 1));

    // random runs
    for (int it = 0; it < 40; it++) begin
      int k; bit reload;
      L = 4 + int'($urandom % 60);
      k = int'($urandom % (L + 4));
      reload = bit'($urandom % 2);
      wr(A_CTRL, 0); wr(A_START, 32'(L)); wr(A_CTRL, {30'b0, reload, 1'b1});
      idle(k);
      chk("R3 random irq", {31'b0, irqOut}, (k >= L) ? 1 : 0);
      rd(A_COUNT, v); chk(reload ? "R4 random count" : "R5 random count", v, expCount(L, k, reload));
      rd(A_STAT, v);  chk("R6 random status", v, (k + 1 >= L) ? 1 : 0);
    end

    wr(A_CTRL, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule